// File: doc/BRIEF.md
# Running Extremes Tracker with Midpoint Output

This block follows a stream of unsigned samples and keeps three registers: the smallest sample seen so far, the largest sample seen so far, and the most recent sample. Each cycle it accepts one operation code. The track operation tests the incoming word against both extremes, using two separate magnitude comparators, and loads whichever extreme the word moves past. In the same step it registers the midpoint of the updated extremes. The midpoint comes from one shared adder followed by a one-bit right shift.

Two seed operations load both extremes from the input word. One of them also produces a midpoint; the other leaves the output alone. A freeze operation holds everything. A reset, given either as an operation code or on the reset pin, puts the low extreme at all ones and the high extreme at zero. With those values, the first track operation seeds both extremes from its sample.

Top module: `minmax_avg`

## Requirements
- R1: When `rst` is high on an edge, or operation code 3'b001 (reset) is applied, the next cycle shows `min_o` all ones, `max_o` zero, `last_o` zero, `avg_o` zero and `avg_vld` low. The `rst` pin takes priority over any operation code.
- R2: When operation code 3'b101 (track) is applied and `din` is greater than `max_o`, the next cycle shows `max_o` equal to that `din`.
- R3: When track is applied and `din` is less than `min_o`, the next cycle shows `min_o` equal to that `din`.
- R4: When track is applied and `min_o` <= `din` <= `max_o`, both equalities included, `min_o` and `max_o` keep their values.
- R5: One cycle after a track operation, `avg_o` equals the sum of the updated extremes, shifted right by one. The sum is formed one bit wider than the data, so it never overflows, and the result is rounded down. `avg_vld` is high in that same cycle.
- R6: Operation code 3'b010 (seed and emit) loads `din` into both extremes. The next cycle shows `avg_o` equal to `din` and `avg_vld` high.
- R7: Operation code 3'b011 (seed quietly) loads `din` into both extremes. `avg_o` keeps its value and `avg_vld` is low.
- R8: Operation code 3'b100 (freeze), 3'b000 and the unused codes 3'b110 and 3'b111 leave every register and `avg_o` unchanged, with `avg_vld` low.
- R9: `last_o` loads `din` on track, seed-and-emit and seed-quietly, and holds on every other code.
- R10: After any track or seed operation since the last reset, `min_o` <= `max_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 3 | Operation applied on this edge |
| din | input | DATA_W | Unsigned sample |
| min_o | output | DATA_W | Running minimum register |
| max_o | output | DATA_W | Running maximum register |
| last_o | output | DATA_W | Last accepted sample |
| avg_o | output | DATA_W | Midpoint of the extremes |
| avg_vld | output | 1 | High for one cycle when `avg_o` was just produced |

## Verification
Every result is a plain register fed from the inputs. The extremes, the last sample, the midpoint and its valid flag therefore all change exactly one edge after the operation is applied. The bench drives each operation on a falling edge and reads all five outputs on the next falling edge. It drives the next operation at that same moment, so each operation is seen by exactly one rising edge. The `avg_vld` check in every vector confirms that the flag lasts one cycle and does not linger into a following freeze or idle operation.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
   localparam logic [2:0] OP_IDLE    = 3'b000;
   localparam logic [2:0] OP_RESET   = 3'b001;
   localparam logic [2:0] OP_SEED_EM = 3'b010;
   localparam logic [2:0] OP_SEED_Q  = 3'b011;
   localparam logic [2:0] OP_FREEZE  = 3'b100;
   localparam logic [2:0] OP_TRACK   = 3'b101;

   typedef struct packed {
      logic init;
      logic seed;
      logic ld_max;
      logic ld_min;
      logic ld_last;
      logic ld_avg;
      logic mark;
   } mm_ctl_t;
endpackage

// File: rtl/mm_cmp.sv
// Unsigned magnitude comparator: gt = (a > b).
module mm_cmp #(
   parameter int W       = 8,
   parameter bit USE_SUB = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         gt
);
   localparam int DW = W + 1;

   generate
      if (W < 1) begin : g_bad_w
         $error("mm_cmp: W must be at least 1");
      end
      if (USE_SUB) begin : g_sub
         logic [DW-1:0] diff;
         // borrow out of b - a means a > b
         assign diff = {1'b0, b} - {1'b0, a};
         assign gt   = diff[DW-1];
      end else begin : g_rel
         assign gt = (a > b);
      end
   endgenerate
endmodule

// File: rtl/mm_avg.sv
// Add-and-shift midpoint, sum carried one bit wider than the data.
module mm_avg #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] mid
);
   localparam int SW = W + 1;

   logic [SW-1:0] sum;

   assign sum = {1'b0, x} + {1'b0, y};
   assign mid = sum[SW-1:1];
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
   import minmax_pkg::*;
(
   input  logic [2:0] op_code,
   input  logic       gt_max,
   input  logic       lt_min,
   output mm_ctl_t    ctl
);
   always_comb begin
      ctl = '0;
      case (op_code)
         OP_RESET: ctl.init = 1'b1;
         OP_SEED_EM: begin
            ctl.seed    = 1'b1;
            ctl.ld_last = 1'b1;
            ctl.ld_avg  = 1'b1;
            ctl.mark    = 1'b1;
         end
         OP_SEED_Q: begin
            ctl.seed    = 1'b1;
            ctl.ld_last = 1'b1;
            ctl.mark    = 1'b1;
         end
         OP_TRACK: begin
            ctl.ld_max  = gt_max;
            ctl.ld_min  = lt_min;
            ctl.ld_last = 1'b1;
            ctl.ld_avg  = 1'b1;
            ctl.mark    = 1'b1;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/minmax_avg.sv
module minmax_avg
   import minmax_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit CMP_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op_code,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] min_o,
   output logic [DATA_W-1:0] max_o,
   output logic [DATA_W-1:0] last_o,
   output logic [DATA_W-1:0] avg_o,
   output logic              avg_vld
);
   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] ALL_ZERO = {DATA_W{1'b0}};

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("minmax_avg: DATA_W must be at least 2");
      end
   endgenerate

   logic              gt_max, lt_min;
   mm_ctl_t           ctl;
   logic [DATA_W-1:0] nxt_min, nxt_max, mid_w;
   logic              seeded_q;

   mm_cmp #(.W(DATA_W), .USE_SUB(CMP_SUB)) u_cmp_hi (
      .a (din), .b (max_o), .gt (gt_max)
   );
   mm_cmp #(.W(DATA_W), .USE_SUB(CMP_SUB)) u_cmp_lo (
      .a (min_o), .b (din), .gt (lt_min)
   );

   mm_ctrl u_ctrl (
      .op_code (op_code), .gt_max (gt_max), .lt_min (lt_min), .ctl (ctl)
   );

   always_comb begin
      nxt_max = (ctl.seed || ctl.ld_max) ? din : max_o;
      nxt_min = (ctl.seed || ctl.ld_min) ? din : min_o;
   end

   mm_avg #(.W(DATA_W)) u_avg (
      .x (nxt_max), .y (nxt_min), .mid (mid_w)
   );

   always_ff @(posedge clk) begin
      if (rst || ctl.init) begin
         min_o    <= ALL_ONES;
         max_o    <= ALL_ZERO;
         last_o   <= ALL_ZERO;
         avg_o    <= ALL_ZERO;
         avg_vld  <= 1'b0;
         seeded_q <= 1'b0;
      end else begin
         min_o   <= nxt_min;
         max_o   <= nxt_max;
         avg_vld <= ctl.ld_avg;
         if (ctl.ld_last) last_o <= din;
         if (ctl.ld_avg)  avg_o  <= mid_w;
         if (ctl.mark)    seeded_q <= 1'b1;
      end
   end

   // R2
   max_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (op_code == OP_TRACK && din > max_o) |=> (max_o == $past(din)));

   // R3
   min_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (op_code == OP_TRACK && din < min_o) |=> (min_o == $past(din)));

   // R4
   inner_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (op_code == OP_TRACK && din >= min_o && din <= max_o)
      |=> ($stable(min_o) && $stable(max_o)));

   // R6
   seed_emit_chk: assert property (@(posedge clk) disable iff (rst)
      (op_code == OP_SEED_EM)
      |=> (min_o == $past(din) && max_o == $past(din) && avg_o == $past(din) && avg_vld));

   // R8
   freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (op_code == OP_FREEZE)
      |=> ($stable(min_o) && $stable(max_o) && $stable(last_o) && $stable(avg_o) && !avg_vld));

   // R10
   order_chk: assert property (@(posedge clk) disable iff (rst)
      seeded_q |-> (min_o <= max_o));
endmodule

// File: tb/minmax_avg_bench.sv
module minmax_avg_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   op_code = 3'b000;
   logic [W-1:0] din = '0;
   logic [W-1:0] min_o, max_o, last_o, avg_o;
   logic         avg_vld;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   minmax_avg #(.DATA_W(W)) u_minmax_avg (
      .clk (clk), .rst (rst), .op_code (op_code), .din (din),
      .min_o (min_o), .max_o (max_o), .last_o (last_o),
      .avg_o (avg_o), .avg_vld (avg_vld)
   );

   // fields: req[4] op[3] din[8] min[8] max[8] last[8] avg[8] vld[1]
   localparam int NV = 17;
   localparam logic [47:0] VEC [NV] = '{
      {4'd2,  3'd5, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 1'b1}, // R2 first track seeds
      {4'd2,  3'd5, 8'h80, 8'h40, 8'h80, 8'h80, 8'h60, 1'b1}, // R2
      {4'd3,  3'd5, 8'h10, 8'h10, 8'h80, 8'h10, 8'h48, 1'b1}, // R3
      {4'd4,  3'd5, 8'h50, 8'h10, 8'h80, 8'h50, 8'h48, 1'b1}, // R4 inside
      {4'd4,  3'd5, 8'h10, 8'h10, 8'h80, 8'h10, 8'h48, 1'b1}, // R4 equal to min
      {4'd4,  3'd5, 8'h80, 8'h10, 8'h80, 8'h80, 8'h48, 1'b1}, // R4 equal to max
      {4'd8,  3'd4, 8'hFF, 8'h10, 8'h80, 8'h80, 8'h48, 1'b0}, // R8 freeze
      {4'd5,  3'd5, 8'hFF, 8'h10, 8'hFF, 8'hFF, 8'h87, 1'b1}, // R5 wide sum
      {4'd5,  3'd5, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h7F, 1'b1}, // R5 round down
      {4'd7,  3'd3, 8'h33, 8'h33, 8'h33, 8'h33, 8'h7F, 1'b0}, // R7
      {4'd5,  3'd5, 8'h34, 8'h33, 8'h34, 8'h34, 8'h33, 1'b1}, // R5
      {4'd6,  3'd2, 8'hC1, 8'hC1, 8'hC1, 8'hC1, 8'hC1, 1'b1}, // R6
      {4'd8,  3'd0, 8'h05, 8'hC1, 8'hC1, 8'hC1, 8'hC1, 1'b0}, // R8 idle
      {4'd9,  3'd7, 8'h05, 8'hC1, 8'hC1, 8'hC1, 8'hC1, 1'b0}, // R9 unused code
      {4'd5,  3'd5, 8'hC2, 8'hC1, 8'hC2, 8'hC2, 8'hC1, 1'b1}, // R5 truncation
      {4'd1,  3'd1, 8'h77, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0}, // R1 reset op
      {4'd10, 3'd5, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1}  // R10 edge seed
   };

   task automatic chk(input int req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input int req, input logic [W-1:0] emin, input logic [W-1:0] emax,
                          input logic [W-1:0] elast, input logic [W-1:0] eavg, input logic evld);
      chk(req, "min_o",  min_o,  emin);
      chk(req, "max_o",  max_o,  emax);
      chk(req, "last_o", last_o, elast);
      chk(req, "avg_o",  avg_o,  eavg);
      chk(req, "avg_vld", {7'd0, avg_vld}, {7'd0, evld});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 state after pin reset
      chk_all(1, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);

      for (int i = 0; i < NV; i++) begin
         op_code = VEC[i][43:41];
         din     = VEC[i][40:33];
         @(negedge clk);
         chk_all(int'(VEC[i][47:44]), VEC[i][32:25], VEC[i][24:17],
                 VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      end

      // R3 track low value after edge seed, then R1 pin reset dominates a track
      op_code = 3'd5; din = 8'h20;
      @(negedge clk);
      chk_all(3, 8'h20, 8'hFF, 8'h20, 8'h8F, 1'b1);
      rst = 1'b1; din = 8'h99;
      @(negedge clk);
      chk_all(1, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
      rst = 1'b0; op_code = 3'd6; din = 8'h12;
      @(negedge clk);
      // R8 unused code 3'b110 after reset
      chk_all(8, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
      op_code = 3'd0;
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule